// File: doc/BRIEF.md
# Card Command Issue and Status Unit

This block is the command front end of a memory-card host controller. Software programs a 32-bit command argument as two 16-bit halves, then writes a 16-bit command word. That write starts the command. The word carries the opcode, the expected response format, the command class, a busy-expected hint and a clock-burst flag. Serial signalling on the card's command line is left to a separate line engine. This unit hands a frame request to that engine and holds it until the engine reports the frame sent. It then waits for the response, bounded by a programmable timeout counted in card-clock ticks.

Responses are captured into eight 16-bit response registers. A long response fills all eight. A short response fills only the top two. Results and externally reported data-path events collect in a 16-bit status register whose bits are cleared by writing ones. An interrupt output is raised while any status bit is set whose enable bit is also set. A command word with the burst flag set sends no frame. It runs a fixed burst of card clocks instead, which is used both for card initialisation and, with class 3, as a transfer abort.

Top module: `card_cmd_unit`

## Requirements
- R1: After reset, the status, enable, argument and command registers read 0, the timeout register reads 0xFF, irq_o is low and neither eng_req_o nor eng_burst_o is asserted.
- R2: A write to offset 0x00 while the unit is idle launches a command. From the next cycle eng_req_o is high and stays high until eng_sent_i. eng_opcode_o is bits 5:0 of the word, eng_rsp_type_o is bits 10:8, eng_class_o is bits 13:12 and eng_busy_exp_o is bit 11. eng_arg_o is {value at 0x08, value at 0x04}.
- R3: With response type 0, eng_sent_i sets end-of-command (status bit 0) at that edge and the unit returns to idle with no response wait.
- R4: With response type 2 (long), eng_done_i stores eng_resp_i[16i+15:16i] in response register i (offset 0x40+4i, i = 0..7). With a good CRC flag it also sets status bit 0.
- R5: With any other non-zero response type (short), eng_done_i stores eng_resp_i[15:0] at 0x58 and eng_resp_i[31:16] at 0x5C, and response registers 0 to 5 keep their values.
- R6: A response arriving with eng_crc_ok_i low sets command-CRC error (status bit 8) and does not set status bit 0.
- R7: If no response arrives within CTO+1 ticks of tick_i after the frame is sent (CTO being the value at offset 0x18), status bit 7 is set instead of bit 0 and the unit goes idle. A later eng_done_i is ignored.
- R8: A command word with bit 7 set sends no frame. eng_burst_o is held for 80 ticks, after which status bit 0 is set. Class 3 with bit 7 set (an abort) behaves the same way.
- R9: A command write while a command is in flight is ignored: the command readback and the engine fields are unchanged. The write sets the sticky collision flag, status bit 15.
- R10: Writing 1 to a status bit at offset 0x10 clears it and writing 0 leaves it. Writing 0xFFFF clears all bits. An event setting a bit in the same cycle as its clear leaves the bit set.
- R11: irq_o is high exactly when some status bit is set whose bit in the enable register (offset 0x14) is also set.
- R12: evt_i[b] high for a cycle sets status bit b. This is how data-path events such as bit 2 card busy, bit 3 end of data and bit 5 data timeout arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on reg_addr_i) |
| tick_i | input | 1 | One pulse per card clock |
| evt_i | input | 16 | Status set events from the data path |
| irq_o | output | 1 | Interrupt, status AND enable |
| eng_req_o | output | 1 | Frame request to the line engine |
| eng_burst_o | output | 1 | Clock burst in progress |
| eng_opcode_o | output | 6 | Command opcode |
| eng_arg_o | output | 32 | Command argument |
| eng_rsp_type_o | output | 3 | Expected response type |
| eng_class_o | output | 2 | Command class |
| eng_busy_exp_o | output | 1 | Busy signalling expected after response |
| eng_sent_i | input | 1 | Frame fully sent |
| eng_done_i | input | 1 | Response received |
| eng_crc_ok_i | input | 1 | Response CRC good, valid with eng_done_i |
| eng_resp_i | input | 128 | Response payload, valid with eng_done_i |

## Verification
If the sequencer is left in the wrong state, eng_req_o or eng_burst_o shows it from the next cycle. The same fault also appears when a completion lands in the wrong status bit, or never lands. Those bits are read back right after the edge that carries the engine's pulse. A wrong timeout or burst count shifts the cycle at which bit 7 or bit 0 appears. The burst length is therefore counted cycle by cycle. Response routing faults are caught by comparing each of the eight response registers against distinct halves of the payload. A short capture is also checked against leftovers from an earlier long capture.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_BURST} seq_state_e;

  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_ARGL = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_ARGH = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_IE   = 7'h14;
  localparam logic [ADDR_W-1:0] OFS_CTO  = 7'h18;
  localparam logic [ADDR_W-1:0] OFS_RSP0 = 7'h40;

  localparam int unsigned SB_EOC  = 0;
  localparam int unsigned SB_CTO  = 7;
  localparam int unsigned SB_CCRC = 8;
  localparam int unsigned SB_COLL = 15;

  localparam int unsigned CB_INIT = 7;
  localparam int unsigned CB_BUSY = 11;
  localparam logic [2:0] RT_NONE = 3'd0;
  localparam logic [2:0] RT_LONG = 3'd2;
endpackage

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
  import card_cmd_pkg::*;
#(
  parameter int unsigned TO_W        = 8,
  parameter int unsigned BURST_TICKS = 80
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic [15:0]     cmd_i,
  input  logic [TO_W-1:0] cto_i,
  input  logic            tick_i,
  input  logic            eng_sent_i,
  input  logic            eng_done_i,
  input  logic            eng_crc_ok_i,
  output logic            busy_o,
  output logic            eng_req_o,
  output logic            eng_burst_o,
  output logic            capture_o,
  output logic            long_o,
  output logic            eoc_o,
  output logic            cto_o,
  output logic            ccrc_o,
  output logic            coll_o
);
  localparam int unsigned BC_W  = $clog2(BURST_TICKS + 1);
  localparam int unsigned CNT_W = (TO_W > BC_W) ? TO_W : BC_W;

  seq_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic rsp_none_q, rsp_long_q;

  always_comb begin
    st_d      = st_q;
    eoc_o     = 1'b0;
    cto_o     = 1'b0;
    ccrc_o    = 1'b0;
    capture_o = 1'b0;
    unique case (st_q)
      ST_IDLE:
        if (launch_i) st_d = cmd_i[CB_INIT] ? ST_BURST : ST_SEND;
      ST_SEND:
        if (eng_sent_i) begin
          if (rsp_none_q) begin
            eoc_o = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            st_d  = ST_WAIT;
          end
        end
      ST_WAIT:
        if (eng_done_i) begin
          capture_o = 1'b1;
          eoc_o     = eng_crc_ok_i;
          ccrc_o    = !eng_crc_ok_i;
          st_d      = ST_IDLE;
        end else if (tick_i && cnt_q == CNT_W'(cto_i)) begin
          cto_o = 1'b1;
          st_d  = ST_IDLE;
        end
      ST_BURST:
        if (tick_i && cnt_q == CNT_W'(BURST_TICKS - 1)) begin
          eoc_o = 1'b1;
          st_d  = ST_IDLE;
        end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rsp_none_q <= 1'b0;
      rsp_long_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)
        cnt_q <= '0;
      else if (tick_i && (st_q == ST_WAIT || st_q == ST_BURST))
        cnt_q <= cnt_q + 1'b1;
      if (st_q == ST_IDLE && launch_i) begin
        rsp_none_q <= (cmd_i[10:8] == RT_NONE);
        rsp_long_q <= (cmd_i[10:8] == RT_LONG);
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign eng_req_o   = (st_q == ST_SEND);
  assign eng_burst_o = (st_q == ST_BURST);
  assign long_o      = rsp_long_q;
  assign coll_o      = launch_i && (st_q != ST_IDLE);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && !eng_sent_i) |=> eng_req_o); // R2
  AST_EOC_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !busy_o); // R3
  AST_TIMEOUT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cto_o |=> (!busy_o && !eng_req_o)); // R7
  AST_BURST_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_burst_o && !eoc_o) |=> (eng_burst_o && !eng_req_o)); // R8
endmodule

// File: rtl/card_stat_reg.sv
module card_stat_reg #(
  parameter int unsigned SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  input  logic [SW-1:0] set_i,
  input  logic [SW-1:0] ie_i,
  output logic [SW-1:0] stat_o,
  output logic          irq_o
);
  logic [SW-1:0] stat_q, clr;

  assign clr = we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ie_i);

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && set_i == '0) |=> ((stat_q & $past(wdata_i)) == '0)); // R10
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R12
endmodule

// File: rtl/card_rsp_store.sv
module card_rsp_store #(
  parameter int unsigned RW   = 16,
  parameter int unsigned NREG = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic                     long_i,
  input  logic [RW*NREG-1:0]       resp_i,
  output logic [NREG-1:0][RW-1:0]  rsp_o
);
  localparam int unsigned SHORT_BASE = NREG - 2;

  logic [NREG-1:0][RW-1:0] rsp_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i < SHORT_BASE) begin : g_long_only
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              rsp_q[i] <= '0;
        else if (cap_i && long_i) rsp_q[i] <= resp_i[i*RW +: RW];
      end
    end else begin : g_both
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    rsp_q[i] <= '0;
        else if (cap_i) rsp_q[i] <= long_i ? resp_i[i*RW +: RW]
                                           : resp_i[(i-SHORT_BASE)*RW +: RW];
      end
    end
  end

  assign rsp_o = rsp_q;

  AST_SHORT_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !long_i) |=> $stable(rsp_q[0])); // R5
endmodule

// File: rtl/card_cmd_unit.sv
module card_cmd_unit
  import card_cmd_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned TO_W        = 8,
  parameter int unsigned BURST_TICKS = 80,
  parameter int unsigned NRSP        = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  input  logic                 tick_i,
  input  logic [DW-1:0]        evt_i,
  output logic                 irq_o,
  output logic                 eng_req_o,
  output logic                 eng_burst_o,
  output logic [5:0]           eng_opcode_o,
  output logic [2*DW-1:0]      eng_arg_o,
  output logic [2:0]           eng_rsp_type_o,
  output logic [1:0]           eng_class_o,
  output logic                 eng_busy_exp_o,
  input  logic                 eng_sent_i,
  input  logic                 eng_done_i,
  input  logic                 eng_crc_ok_i,
  input  logic [DW*NRSP-1:0]   eng_resp_i
);
  logic [DW-1:0]   cmd_q, argl_q, argh_q, ie_q, stat;
  logic [TO_W-1:0] cto_q;
  logic [NRSP-1:0][DW-1:0] rsp;
  logic wr_cmd, busy, capture, long_rsp, eoc, cto, ccrc, coll;
  logic [DW-1:0] set_vec;

  assign wr_cmd = reg_we_i && reg_addr_i == OFS_CMD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      argl_q <= '0;
      argh_q <= '0;
      ie_q   <= '0;
      cto_q  <= '1;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        OFS_CMD:  if (!busy) cmd_q <= reg_wdata_i;
        OFS_ARGL: argl_q <= reg_wdata_i;
        OFS_ARGH: argh_q <= reg_wdata_i;
        OFS_IE:   ie_q   <= reg_wdata_i;
        OFS_CTO:  cto_q  <= reg_wdata_i[TO_W-1:0];
        default: ;
      endcase
    end
  end

  card_cmd_seq #(.TO_W(TO_W), .BURST_TICKS(BURST_TICKS)) u_seq (
    .clk_i, .rst_ni,
    .launch_i(wr_cmd), .cmd_i(reg_wdata_i), .cto_i(cto_q), .tick_i,
    .eng_sent_i, .eng_done_i, .eng_crc_ok_i,
    .busy_o(busy), .eng_req_o, .eng_burst_o, .capture_o(capture),
    .long_o(long_rsp), .eoc_o(eoc), .cto_o(cto), .ccrc_o(ccrc), .coll_o(coll)
  );

  always_comb begin
    set_vec          = evt_i;
    set_vec[SB_EOC]  = set_vec[SB_EOC] | eoc;
    set_vec[SB_CTO]  = set_vec[SB_CTO] | cto;
    set_vec[SB_CCRC] = set_vec[SB_CCRC] | ccrc;
    set_vec[SB_COLL] = set_vec[SB_COLL] | coll;
  end

  card_stat_reg #(.SW(DW)) u_stat (
    .clk_i, .rst_ni,
    .we_i(reg_we_i && reg_addr_i == OFS_STAT), .wdata_i(reg_wdata_i),
    .set_i(set_vec), .ie_i(ie_q), .stat_o(stat), .irq_o
  );

  card_rsp_store #(.RW(DW), .NREG(NRSP)) u_rsp (
    .clk_i, .rst_ni, .cap_i(capture), .long_i(long_rsp),
    .resp_i(eng_resp_i), .rsp_o(rsp)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CMD:  reg_rdata_o = cmd_q;
      OFS_ARGL: reg_rdata_o = argl_q;
      OFS_ARGH: reg_rdata_o = argh_q;
      OFS_STAT: reg_rdata_o = stat;
      OFS_IE:   reg_rdata_o = ie_q;
      OFS_CTO:  reg_rdata_o = DW'(cto_q);
      default: ;
    endcase
    for (int i = 0; i < NRSP; i++)
      if (reg_addr_i == OFS_RSP0 + ADDR_W'(4*i)) reg_rdata_o = rsp[i];
  end

  assign eng_opcode_o   = cmd_q[5:0];
  assign eng_rsp_type_o = cmd_q[10:8];
  assign eng_class_o    = cmd_q[13:12];
  assign eng_busy_exp_o = cmd_q[CB_BUSY];
  assign eng_arg_o      = {argh_q, argl_q};

  AST_BUSY_CMD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_cmd) |=> $stable(cmd_q)); // R9
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat == '0) |-> !irq_o); // R11
endmodule

// File: tb/card_cmd_unit_bench.sv
module card_cmd_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [6:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic tick = 1'b1;
  logic [15:0] evt = '0;
  logic irq, req, burst, busy_exp, sent = 1'b0, done = 1'b0, crc_ok = 1'b0;
  logic [5:0] opcode;
  logic [31:0] arg;
  logic [2:0] rtype;
  logic [1:0] cls;
  logic [127:0] resp = '0;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cmd_unit u_card_cmd_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_i(tick), .evt_i(evt),
    .irq_o(irq), .eng_req_o(req), .eng_burst_o(burst), .eng_opcode_o(opcode),
    .eng_arg_o(arg), .eng_rsp_type_o(rtype), .eng_class_o(cls),
    .eng_busy_exp_o(busy_exp), .eng_sent_i(sent), .eng_done_i(done),
    .eng_crc_ok_i(crc_ok), .eng_resp_i(resp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmd(logic [5:0] op, logic [2:0] rt, logic [1:0] c,
                                         logic init, logic bsy);
    return {2'b00, c, bsy, rt, init, 1'b0, op};
  endfunction

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_sent();
    sent = 1'b1;
    @(negedge clk);
    sent = 1'b0;
  endtask

  task automatic pulse_done(logic [127:0] r, logic ok);
    resp = r; crc_ok = ok; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic clr_all();
    wr(7'h10, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(7'h10, v); chk("R1 stat", v, 0);
    rd(7'h18, v); chk("R1 cto", v, 16'h00FF);
    rd(7'h00, v); chk("R1 cmd", v, 0);
    chk("R1 irq/req/burst", {irq, req, burst}, 0);
  endtask

  task automatic t_no_resp();
    logic [15:0] v;
    wr(7'h04, 16'h5678);
    wr(7'h08, 16'h1234);
    wr(7'h00, mk_cmd(6'd0, 3'd0, 2'd0, 1'b0, 1'b1));
    chk("R2 req", req, 1);
    chk("R2 arg", arg, 32'h12345678);
    chk("R2 busy flag", busy_exp, 1);
    @(negedge clk);
    chk("R2 req held", req, 1);
    pulse_sent();
    chk("R3 req drop", req, 0);
    rd(7'h10, v); chk("R3 eoc", v, 16'h0001);
    clr_all();
  endtask

  task automatic t_long();
    logic [127:0] r;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = 16'hA000 + 16'(i * 16'h111);
    wr(7'h00, mk_cmd(6'd2, 3'd2, 2'd1, 1'b0, 1'b0));
    chk("R2 fields", {26'd0, opcode}, 2);
    chk("R2 type/class", {27'd0, rtype, cls}, {27'd0, 3'd2, 2'd1});
    pulse_sent();
    repeat (2) @(negedge clk);
    pulse_done(r, 1'b1);
    for (int i = 0; i < 8; i++) begin
      rd(7'(7'h40 + 4*i), v);
      chk("R4 rsp", v, r[16*i +: 16]);
    end
    rd(7'h10, v); chk("R4 eoc", v, 16'h0001);
    clr_all();
  endtask

  task automatic t_short();
    logic [15:0] v;
    wr(7'h00, mk_cmd(6'd13, 3'd1, 2'd2, 1'b0, 1'b0));
    pulse_sent();
    pulse_done({96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hBEEF_CAFE}, 1'b1);
    rd(7'h58, v); chk("R5 rsp6", v, 16'hCAFE);
    rd(7'h5C, v); chk("R5 rsp7", v, 16'hBEEF);
    rd(7'h54, v); chk("R5 rsp5 kept", v, 16'hA555);
    rd(7'h40, v); chk("R5 rsp0 kept", v, 16'hA000);
    clr_all();
  endtask

  task automatic t_crc();
    logic [15:0] v;
    wr(7'h00, mk_cmd(6'd3, 3'd6, 2'd1, 1'b0, 1'b0));
    pulse_sent();
    pulse_done(128'h1, 1'b0);
    rd(7'h10, v); chk("R6 crc only", v, 16'h0100);
    chk("R6 idle", req, 0);
    clr_all();
  endtask

  task automatic t_timeout();
    logic [15:0] v;
    wr(7'h18, 16'd5);
    wr(7'h00, mk_cmd(6'd8, 3'd1, 2'd1, 1'b0, 1'b0));
    pulse_sent();
    repeat (3) @(negedge clk);
    rd(7'h10, v); chk("R7 not yet", v, 0);
    repeat (10) @(negedge clk);
    rd(7'h10, v); chk("R7 timeout", v, 16'h0080);
    pulse_done(128'h5, 1'b1);
    rd(7'h10, v); chk("R7 late ignored", v, 16'h0080);
    wr(7'h18, 16'h00FF);
    clr_all();
  endtask

  task automatic t_burst(logic [1:0] c);
    logic [15:0] v;
    int n = 0, saw_req = 0;
    wr(7'h00, mk_cmd(6'd0, 3'd0, c, 1'b1, 1'b0));
    for (int k = 0; k < 200 && burst; k++) begin
      n++;
      if (req) saw_req++;
      @(negedge clk);
    end
    chk("R8 burst len", n, 80);
    chk("R8 no frame", saw_req, 0);
    rd(7'h10, v); chk("R8 eoc", v, 16'h0001);
    clr_all();
  endtask

  task automatic t_collision();
    logic [15:0] v, c0;
    c0 = mk_cmd(6'd17, 3'd1, 2'd2, 1'b0, 1'b0);
    wr(7'h00, c0);
    wr(7'h00, mk_cmd(6'd5, 3'd0, 2'd0, 1'b0, 1'b0));
    rd(7'h00, v); chk("R9 cmd kept", v, c0);
    chk("R9 opcode kept", opcode, 17);
    rd(7'h10, v); chk("R9 coll flag", v, 16'h8000);
    pulse_sent();
    pulse_done(128'h7, 1'b1);
    rd(7'h10, v); chk("R9 sticky", v, 16'h8001);
    clr_all();
  endtask

  task automatic t_w1c_irq();
    logic [15:0] v;
    @(negedge clk); evt = 16'h0028; @(negedge clk); evt = '0;
    rd(7'h10, v); chk("R12 evt set", v, 16'h0028);
    wr(7'h10, 16'h0008);
    rd(7'h10, v); chk("R10 w1c", v, 16'h0020);
    @(negedge clk);
    we = 1'b1; addr = 7'h10; wdata = 16'h0020; evt = 16'h0020;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd(7'h10, v); chk("R10 set wins", v, 16'h0020);
    clr_all();
    rd(7'h10, v); chk("R10 clear all", v, 0);
    wr(7'h14, 16'h0004);
    @(negedge clk); evt = 16'h0008; @(negedge clk); evt = '0;
    chk("R11 masked", irq, 0);
    @(negedge clk); evt = 16'h0004; @(negedge clk); evt = '0;
    chk("R11 enabled", irq, 1);
    wr(7'h10, 16'h0004);
    chk("R11 cleared", irq, 0);
    clr_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_resp();
    t_long();
    t_short();
    t_crc();
    t_timeout();
    t_burst(2'd0);
    t_burst(2'd3);
    t_collision();
    t_w1c_irq();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule